// File: doc/BRIEF.md
# Prescaled Down-Counting Interrupt Timer

This block is a programmable interval timer for a small 8-bit controller. An 8-bit down counter advances once per output tick of a 7-bit prescaler. The prescaler is fed either by the block's own clock, where every cycle counts as one source edge, or by falling edges of an external pin. That pin passes through a two-flop synchronizer before edge detection. A control register picks the source, stops or runs the chain, chooses a power-of-two division ratio and can restart the prescaler from zero.

When a decrement brings the counter to zero, a sticky request flag in the control register is set. A mask bit next to the flag decides whether the flag drives the interrupt output. Software reaches the counter and the control register through a one-bit-address register bus with a single-cycle write and a combinational read. The counter keeps running through zero, wrapping to 0xFF.

Top module: `pdt_timer`

## Requirements
- R1: After reset the counter reads 0xFF, the control register reads 0x50 (mask bit 6 set, stop bit 4 set, all other bits 0) and irq_o is low.
- R2: On each prescaler tick the counter decrements by one, and a decrement from 0x00 gives 0xFF.
- R3: Control bits 2:0 hold n. A tick occurs on every 2^n-th source edge, and the first one comes on the 2^n-th source edge after the prescaler is cleared.
- R4: Control bit 7 is set by a decrement that yields 0x00 and stays set until a control write with bit 7 at 0. Writing 1 to bit 7 never sets it, and a set in the same cycle as a clear wins.
- R5: irq_o is high exactly while bit 7 is 1 and bit 6 is 0.
- R6: While control bit 4 is 1, the prescaler and the counter hold their values.
- R7: With control bit 5 at 0, every clock cycle is a source edge. With bit 5 at 1, only a falling edge of ext_i, seen after two synchronizing flops, is a source edge, and rising edges do nothing.
- R8: A control write with bit 3 at 1 clears the prescaler to zero. Bit 3 always reads 0.
- R9: A counter write takes priority over a decrement in the same cycle. The written value is read in the next cycle, and the write never sets the flag.
- R10: addr_i at 0 selects the counter and addr_i at 1 selects the control register. A write commits on the clock edge where wr_i is high, and rdata_o shows the selected register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; also the internal count source |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_i | input | 1 | External count pin, asynchronous |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 counter, 1 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Qualified timer interrupt request |

## Verification
If the prescaler holds a wrong value, the count period shifts. At the 128 ratio the counter read on the bus can take up to 128 cycles to differ from the expected value, while at ratio 1 it differs on the next cycle. A wrong counter value or flag shows on rdata_o and irq_o in the cycle after the edge that corrupted it. A reference model fed with the same stimulus therefore compares both outputs every cycle. A synchronizer or edge-detect fault on the external path only shows up as a missing or extra decrement three cycles after the pin falls, so the bench drives that path with slow, well-separated pin transitions.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
  parameter int CNT_W = 8;
  parameter int PRE_W = 7;
  parameter int SEL_W = 3;
  parameter int SYNC_STAGES = 2;

  localparam int B_FLAG = 7;
  localparam int B_MASK = 6;
  localparam int B_EXT  = 5;
  localparam int B_STOP = 4;
  localparam int B_CLR  = 3;

  localparam logic [CNT_W-1:0] CNT_RST = '1;

  typedef struct packed {
    logic             flag;
    logic             mask;
    logic             ext_sel;
    logic             stop;
    logic [SEL_W-1:0] ratio;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{flag: 1'b0, mask: 1'b1, ext_sel: 1'b0,
                                 stop: 1'b1, ratio: '0};
endpackage

// File: rtl/pdt_src_sel.sv
module pdt_src_sel #(
  parameter int SYNC = pdt_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic ext_sel_i,
  input  logic stop_i,
  output logic src_tick_o
);
  logic [SYNC-1:0] sync_q;
  logic            last_q;
  logic            ext_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], ext_i};
      last_q <= sync_q[SYNC-1];
    end
  end

  assign ext_fall   = last_q & ~sync_q[SYNC-1];
  assign src_tick_o = ~stop_i & (ext_sel_i ? ext_fall : 1'b1);

  a_r7_ext_needs_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_tick_o && ext_sel_i) |-> (last_q && !sync_q[SYNC-1]));
endmodule

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
  parameter int PRE_W = pdt_pkg::PRE_W,
  parameter int SEL_W = pdt_pkg::SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_tick_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] ratio_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] tap_mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) tap_mask[i] = (ratio_i > SEL_W'(i));
  end

  // tick when every bit below the tap is about to carry
  assign tick_o = src_tick_i & ((pre_q & tap_mask) == tap_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pre_q <= '0;
    else if (clr_i)      pre_q <= '0;
    else if (src_tick_i) pre_q <= pre_q + 1'b1;
  end

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pre_q == '0));
  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !src_tick_i) |=> $stable(pre_q));
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
  parameter int CNT_W = pdt_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_evt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= pdt_pkg::CNT_RST;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= cnt_q - ONE;
  end

  assign cnt_o      = cnt_q;
  assign zero_evt_o = tick_i & ~load_i & (cnt_q == ONE);

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i) |=> (cnt_q == $past(cnt_q) - ONE));
  a_r9_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pdt_timer.sv
module pdt_timer
  import pdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_i,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic             irq_o
);
  ctrl_t            ctrl_q;
  logic             ctrl_wr;
  logic             cnt_wr;
  logic             pre_clr;
  logic             src_tick;
  logic             pre_tick;
  logic             zero_evt;
  logic [CNT_W-1:0] cnt;

  assign ctrl_wr = wr_i &  addr_i;
  assign cnt_wr  = wr_i & ~addr_i;
  assign pre_clr = ctrl_wr & wdata_i[B_CLR];

  pdt_src_sel #(.SYNC(SYNC_STAGES)) u_src (
    .clk_i, .rst_ni, .ext_i,
    .ext_sel_i (ctrl_q.ext_sel),
    .stop_i    (ctrl_q.stop),
    .src_tick_o(src_tick)
  );

  pdt_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk_i, .rst_ni,
    .src_tick_i(src_tick),
    .clr_i     (pre_clr),
    .ratio_i   (ctrl_q.ratio),
    .tick_o    (pre_tick)
  );

  pdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i    (pre_tick),
    .load_i    (cnt_wr),
    .load_val_i(wdata_i),
    .cnt_o     (cnt),
    .zero_evt_o(zero_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.mask    <= wdata_i[B_MASK];
        ctrl_q.ext_sel <= wdata_i[B_EXT];
        ctrl_q.stop    <= wdata_i[B_STOP];
        ctrl_q.ratio   <= wdata_i[SEL_W-1:0];
      end
      // set beats clear so a zero crossing is never lost
      if (zero_evt)                          ctrl_q.flag <= 1'b1;
      else if (ctrl_wr && !wdata_i[B_FLAG]) ctrl_q.flag <= 1'b0;
    end
  end

  assign irq_o   = ctrl_q.flag & ~ctrl_q.mask;
  assign rdata_o = addr_i ? {ctrl_q.flag, ctrl_q.mask, ctrl_q.ext_sel, ctrl_q.stop,
                             1'b0, ctrl_q.ratio}
                          : cnt;

  a_r4_set_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_evt |=> ctrl_q.flag);
  a_r4_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.flag && !(ctrl_wr && !wdata_i[B_FLAG])) |=> ctrl_q.flag);
  a_r4_no_sw_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.flag && !zero_evt) |=> !ctrl_q.flag);
endmodule

// File: tb/pdt_timer_tb.sv
`timescale 1ns/1ps
module pdt_timer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_i = 1'b1;
  logic       wr_i = 1'b0;
  logic       addr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pdt_timer u_dut (.*);

  typedef struct { logic [7:0] cnt; logic [7:0] ctrl; logic irq; } item_t;
  item_t sb_q[$];

  // reference model from the requirements
  logic [7:0] m_cnt;
  logic       m_flag, m_mask, m_ext, m_stop;
  logic [2:0] m_ratio;
  int         m_pre;
  logic       m_s1, m_s2, m_last;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 8'hFF; m_flag = 0; m_mask = 1; m_ext = 0; m_stop = 1;
      m_ratio = 0; m_pre = 0; m_s1 = 0; m_s2 = 0; m_last = 0;
      sb_q.delete();
    end else begin
      automatic bit src, tick, set, cw, kw;
      automatic int div = 1 << m_ratio;
      item_t it;
      cw  = wr_i && addr_i;
      kw  = wr_i && !addr_i;
      src = !m_stop && (m_ext ? (m_last && !m_s2) : 1'b1);
      tick = src && ((m_pre % div) == div - 1);
      m_last = m_s2; m_s2 = m_s1; m_s1 = ext_i;
      if (cw && wdata_i[3]) m_pre = 0;
      else if (src) m_pre = (m_pre + 1) % 128;
      set = 0;
      if (kw) m_cnt = wdata_i;
      else if (tick) begin
        if (m_cnt == 8'h01) set = 1;
        m_cnt = m_cnt - 8'h01;
      end
      if (set) m_flag = 1;
      else if (cw && !wdata_i[7]) m_flag = 0;
      if (cw) begin
        m_mask = wdata_i[6]; m_ext = wdata_i[5]; m_stop = wdata_i[4];
        m_ratio = wdata_i[2:0];
      end
      it.cnt  = m_cnt;
      it.ctrl = {m_flag, m_mask, m_ext, m_stop, 1'b0, m_ratio};
      it.irq  = m_flag && !m_mask;
      sb_q.push_back(it);
    end
  end

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && sb_q.size() > 0) begin
      automatic item_t it = sb_q.pop_front();
      automatic logic [7:0] exp = addr_i ? it.ctrl : it.cnt;
      checks++;
      if (rdata_o !== exp) begin
        errors++;
        $display("FAIL R2/R10 scoreboard rdata: actual %h expected %h", rdata_o, exp);
      end
      checks++;
      if (irq_o !== it.irq) begin
        errors++;
        $display("FAIL R5 scoreboard irq: actual %b expected %b", irq_o, it.irq);
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(posedge clk_i); #1;
    wr_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_i = 0; addr_i = 0;
  endtask

  task automatic rd_ctrl(output logic [7:0] v);
    addr_i = 1; #0.5; v = rdata_o; addr_i = 0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  logic [7:0] v;

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cycles(3); #0.5;
    rst_ni = 1;
    cycles(1);
    // R1 reset state
    check("R1 counter", rdata_o, 8'hFF);
    rd_ctrl(v); check("R1 ctrl", v, 8'h50);
    check("R1 irq", {7'b0, irq_o}, 8'h00);

    // R8 bit3 reads 0; R6 stopped counter holds
    wr(1, 8'h58);
    rd_ctrl(v); check("R8 clr bit reads 0", v, 8'h50);
    cycles(20);
    check("R6 stopped hold", rdata_o, 8'hFF);

    // R3 ratio /4
    wr(0, 8'h0A);
    wr(1, 8'h0A);
    cycles(14);
    check("R3 div4 after 14", rdata_o, 8'h07);

    // R8/R3 prescaler restart at /8
    wr(1, 8'h1B);
    wr(0, 8'h20);
    wr(1, 8'h0B);
    cycles(4);
    wr(1, 8'h0B);
    cycles(7);
    check("R8 no tick before 8 after clear", rdata_o, 8'h20);
    cycles(1);
    check("R3 first tick at 8", rdata_o, 8'h1F);

    // R2/R4/R5 zero crossing and wrap
    wr(1, 8'h1A);
    wr(0, 8'h02);
    wr(1, 8'h08);
    cycles(2);
    check("R4 reached zero", rdata_o, 8'h00);
    check("R5 irq up", {7'b0, irq_o}, 8'h01);
    cycles(1);
    check("R2 wrap to FF", rdata_o, 8'hFF);
    rd_ctrl(v); check("R4 flag set", v, 8'h80);

    // R5 mask, R4 sticky with write of 1
    wr(1, 8'hC8);
    check("R5 masked irq low", {7'b0, irq_o}, 8'h00);
    rd_ctrl(v); check("R4 flag kept", v, 8'hC0);
    wr(1, 8'h50);
    rd_ctrl(v); check("R4 flag cleared", v, 8'h50);
    wr(1, 8'h90);
    rd_ctrl(v); check("R4 write 1 no set", v, 8'h10);
    check("R5 irq low no flag", {7'b0, irq_o}, 8'h00);

    // R9 write wins, no flag from write
    wr(1, 8'h08);
    wr(0, 8'h33);
    check("R9 load wins", rdata_o, 8'h33);
    cycles(1);
    check("R9 then decrement", rdata_o, 8'h32);
    wr(0, 8'h00);
    rd_ctrl(v); check("R9 write no flag", v, 8'h00);

    // R7 external source
    wr(1, 8'h38);
    wr(0, 8'h50);
    wr(1, 8'h28);
    cycles(10);
    check("R7 internal ignored", rdata_o, 8'h50);
    for (int i = 0; i < 5; i++) begin
      ext_i = 0; cycles(4);
      ext_i = 1; cycles(4);
    end
    cycles(6);
    check("R7 five falls", rdata_o, 8'h4B);

    // R10 mixed traffic under scoreboard
    for (int i = 0; i < 4000; i++) begin
      automatic int r = $urandom_range(0, 99);
      if (r < 3) wr(1, 8'($urandom()));
      else if (r < 6) wr(0, 8'($urandom()));
      else begin
        if (r < 30) ext_i = ~ext_i;
        if (r > 90) begin addr_i = 1; cycles(1); addr_i = 0; end
        else cycles(1);
      end
    end
    wr(1, 8'h50);
    cycles(3);
    rd_ctrl(v); check("R10 final ctrl", v, 8'h50);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule